// File: doc/BRIEF.md
# SHA-1 Message Schedule Helper

This block speeds up building the SHA-1 message schedule four 32-bit words at a time. It works on 128-bit vectors made of four packed 32-bit lanes. Lane 0 is bits 31:0 and lane 3 is bits 127:96. A 2-bit opcode picks one of three operations on two vector operands:

- **Mixing step.** The first XOR stage of the schedule recurrence.
- **Completion step.** The final XOR followed by a one-bit left rotate. Its last output lane depends on its own first output lane.
- **E-fold step.** Adds a rotated copy of the previous working variable E into the top lane of the next message group.

The operands and the opcode are taken in on a valid strobe. The result lands in a register one cycle later, together with an output valid flag. Software or a surrounding engine issues the operations in sequence. That caller keeps the sliding message window and runs the compression rounds itself.

Top module: `sha1_sched_helper`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise. `out_data` carries the result of that accepted operation in the same cycle.
- R3: After a cycle with `in_valid` low, `out_data` keeps its previous value, whatever `in_op`, `in_a` and `in_b` hold.
- R4: Opcode 0 (mixing) forms the result as follows, with lane k of operand x written xk:
  - lane 3 is a3^a1
  - lane 2 is a2^a0
  - lane 1 is a1^b3
  - lane 0 is a0^b2
- R5: Opcode 1 (completion) sets the upper three lanes as follows, with ROL1 a left rotate by one bit inside a 32-bit lane:
  - lane 3 is ROL1(a3^b2)
  - lane 2 is ROL1(a2^b1)
  - lane 1 is ROL1(a1^b0)
- R6: Opcode 1 sets lane 0 to ROL1(a0^L3), where L3 is the lane 3 value produced by the same operation.
- R7: Opcode 2 (E-fold) sets lane 3 to (b3 + ROL30(a3)) mod 2^32.
- R8: Opcode 2 passes lanes 2, 1 and 0 of operand b to the result unchanged.
- R9: Opcode 3 produces an all-zero result, and `out_valid` still rises as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: accept operands and opcode this cycle |
| in_op | input | 2 | Operation select: 0 mixing, 1 completion, 2 E-fold, 3 unused |
| in_a | input | 128 | First vector operand, four 32-bit lanes |
| in_b | input | 128 | Second vector operand, four 32-bit lanes |
| out_valid | output | 1 | Result register holds a freshly accepted result |
| out_data | output | 128 | Registered 128-bit result |

## Verification
Every opcode is driven with a single set bit walked across all 256 operand bit positions, with the other operand zero. Each walking bit shows exactly which output lanes and bit positions that input reaches, so a swapped lane, a wrong rotate amount or a misrouted operand shows up as a bit in the wrong place. A seeded pseudo-random sweep then covers each opcode with dense operands, which exercises the carry chain of the E-fold addition and the chained lane-0 term of the completion step. Idle cycles with changing inputs between operations confirm that the result holds and that the valid flag pulses for only one cycle.

// File: rtl/sha1_sched_pkg.sv
package sha1_sched_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int OP_W   = 2;

    // Rotate amounts fixed by the schedule recurrence and the E fold
    localparam int SCHED_ROT = 1;
    localparam int EFOLD_ROT = 30;

    typedef logic [LANE_W-1:0] lane_t;
    // Element k of a vector sits at bits [LANE_W*k +: LANE_W]
    typedef lane_t [LANES-1:0] vec_t;

    typedef enum logic [OP_W-1:0] {
        OP_MIX    = 2'd0,
        OP_FINISH = 2'd1,
        OP_EFOLD  = 2'd2,
        OP_NONE   = 2'd3
    } sched_op_e;

    typedef struct packed {
        logic valid;
        vec_t data;
    } sched_res_t;

    function automatic lane_t rotl(input lane_t x, input int unsigned n);
        lane_t r;
        r = (x << n) | (x >> (LANE_W - n));
        return r;
    endfunction

endpackage

// File: rtl/sha1_sched_mix.sv
// First schedule stage: XOR of words two apart across a six-word window
module sha1_sched_mix
    import sha1_sched_pkg::*;
(
    input  vec_t              a,
    input  lane_t [1:0]       b_hi,   // b lanes 3 and 2
    output vec_t              y
);
    localparam int WIN = LANES + 2;

    lane_t win [WIN];

    // Window order oldest first: a lanes 3..0, then b lanes 3, 2
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_win_a
            assign win[g] = a[LANES-1-g];
        end
        for (g = 0; g < 2; g++) begin : g_win_b
            assign win[LANES+g] = b_hi[1-g];
        end
        for (g = 0; g < LANES; g++) begin : g_out
            assign y[LANES-1-g] = win[g+2] ^ win[g];
        end
    endgenerate

endmodule

// File: rtl/sha1_sched_finish.sv
// Second schedule stage: final XOR plus rotate, last lane chained on the first
module sha1_sched_finish
    import sha1_sched_pkg::*;
(
    input  vec_t                    a,
    input  lane_t [LANES-2:0]       b_lo,   // b lanes 2..0
    output vec_t                    y
);
    genvar g;
    generate
        for (g = 1; g < LANES; g++) begin : g_upper
            assign y[g] = rotl(a[g] ^ b_lo[g-1], SCHED_ROT);
        end
    endgenerate

    // Lowest lane depends on the freshly produced top lane
    assign y[0] = rotl(a[0] ^ y[LANES-1], SCHED_ROT);

endmodule

// File: rtl/sha1_sched_efold.sv
// Adds rotated previous-E into the top lane; lower lanes pass through
module sha1_sched_efold
    import sha1_sched_pkg::*;
(
    input  lane_t a_top,
    input  vec_t  b,
    output vec_t  y
);
    assign y[LANES-1] = b[LANES-1] + rotl(a_top, EFOLD_ROT);

    genvar g;
    generate
        for (g = 0; g < LANES - 1; g++) begin : g_pass
            assign y[g] = b[g];
        end
    endgenerate

endmodule

// File: rtl/sha1_sched_helper.sv
module sha1_sched_helper
    import sha1_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    vec_t       opa, opb;
    vec_t       mix_y, fin_y, fold_y;
    vec_t       sel_y;
    sched_op_e  op;
    sched_res_t res_q;

    assign opa = vec_t'(in_a);
    assign opb = vec_t'(in_b);
    assign op  = sched_op_e'(in_op);

    sha1_sched_mix u_mix (
        .a    (opa),
        .b_hi ({opb[LANES-1], opb[LANES-2]}),
        .y    (mix_y)
    );

    sha1_sched_finish u_finish (
        .a    (opa),
        .b_lo (opb[LANES-2:0]),
        .y    (fin_y)
    );

    sha1_sched_efold u_efold (
        .a_top (opa[LANES-1]),
        .b     (opb),
        .y     (fold_y)
    );

    always_comb begin
        unique case (op)
            OP_MIX:    sel_y = mix_y;
            OP_FINISH: sel_y = fin_y;
            OP_EFOLD:  sel_y = fold_y;
            default:   sel_y = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.data <= sel_y;
            end
        end
    end

    assign out_valid = res_q.valid;
    assign out_data  = res_q.data;

endmodule

// File: rtl/sha1_sched_helper_chk.sv
module sha1_sched_helper_chk
    import sha1_sched_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic [VEC_W-1:0] in_a,
    input logic [VEC_W-1:0] in_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data
);
    // R1: reset clears the result register
    always @(posedge clk) begin
        if (rst) begin
            #1;
            a_reset_r1: assert (!out_valid && out_data == '0);
        end
    end

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    p_mix_top_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0) |=>
        out_data[127:96] == ($past(in_a[127:96]) ^ $past(in_a[63:32])));

    p_mix_low_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0) |=>
        out_data[31:0] == ($past(in_a[31:0]) ^ $past(in_b[95:64])));

    p_fin_mid_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1) |=>
        out_data[95:64] == rotl($past(in_a[95:64]) ^ $past(in_b[63:32]), 1));

    p_fin_chain_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1) |=>
        out_data[31:0] == rotl($past(in_a[31:0]) ^ out_data[127:96], 1));

    p_fold_top_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2) |=>
        out_data[127:96] == lane_t'($past(in_b[127:96]) + rotl($past(in_a[127:96]), 30)));

    p_fold_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2) |=>
        out_data[95:0] == $past(in_b[95:0]));

    p_none_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=> out_data == '0);

endmodule

bind sha1_sched_helper sha1_sched_helper_chk u_chk (.*);

// File: tb/tb_sha1_sched_helper.sv
`timescale 1ns/1ps
module tb_sha1_sched_helper;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = 2'd0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    sha1_sched_helper dut (
        .clk, .rst, .in_valid, .in_op, .in_a, .in_b, .out_valid, .out_data
    );

    function automatic logic [31:0] ln(input logic [127:0] v, input int k);
        return v[32*k +: 32];
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        logic [31:0] r = x;
        for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
        return r;
    endfunction

    function automatic logic [127:0] model(input logic [1:0] op,
                                           input logic [127:0] a,
                                           input logic [127:0] b);
        logic [31:0] l3, l2, l1, l0;
        case (op)
            2'd0: begin
                l3 = ln(a,3) ^ ln(a,1); l2 = ln(a,2) ^ ln(a,0);
                l1 = ln(a,1) ^ ln(b,3); l0 = ln(a,0) ^ ln(b,2);
            end
            2'd1: begin
                l3 = rl(ln(a,3) ^ ln(b,2), 1); l2 = rl(ln(a,2) ^ ln(b,1), 1);
                l1 = rl(ln(a,1) ^ ln(b,0), 1); l0 = rl(ln(a,0) ^ l3, 1);
            end
            2'd2: begin
                l3 = ln(b,3) + rl(ln(a,3), 30);
                l2 = ln(b,2); l1 = ln(b,1); l0 = ln(b,0);
            end
            default: begin
                l3 = '0; l2 = '0; l1 = '0; l0 = '0;
            end
        endcase
        return {l3, l2, l1, l0};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic next_rand(output logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            v[32*i +: 32] = seed ^ {seed[15:0], seed[31:16]};
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [127:0] a, input logic [127:0] b);
        logic [127:0] exp, junk;
        exp = model(op, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        next_rand(junk); in_a = junk; in_b = ~junk; in_op = junk[1:0];
        check("R2", {127'd0, out_valid}, 128'd1);
        case (op)
            2'd0: check("R4", out_data, exp);
            2'd1: begin
                check("R5", {out_data[127:32], 32'd0}, {exp[127:32], 32'd0});
                check("R6", {96'd0, out_data[31:0]}, {96'd0, exp[31:0]});
            end
            2'd2: begin
                check("R7", {out_data[127:96], 96'd0}, {exp[127:96], 96'd0});
                check("R8", {32'd0, out_data[95:0]}, {32'd0, exp[95:0]});
            end
            default: check("R9", out_data, 128'd0);
        endcase
        @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);
        check("R3", out_data, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] ra, rb;
        repeat (3) @(negedge clk);
        check("R1", {127'd0, out_valid}, 128'd0);
        check("R1", out_data, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {127'd0, out_valid}, 128'd0);
        check("R1", out_data, 128'd0);

        for (int op = 0; op < 4; op++) begin
            for (int bit_i = 0; bit_i < 128; bit_i++) begin
                run_op(op[1:0], 128'd1 << bit_i, 128'd0);
                run_op(op[1:0], 128'd0, 128'd1 << bit_i);
            end
        end
        for (int op = 0; op < 4; op++) begin
            for (int n = 0; n < 300; n++) begin
                next_rand(ra); next_rand(rb);
                run_op(op[1:0], ra, rb);
            end
            run_op(op[1:0], '1, '1);
        end
        // Back-to-back strobes: valid stays high, each result lands in turn
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd2; in_a = '1; in_b = '1;
        @(negedge clk);
        in_op = 2'd0;
        check("R2", {127'd0, out_valid}, 128'd1);
        check("R7", out_data, model(2'd2, '1, '1));
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {127'd0, out_valid}, 128'd1);
        check("R4", out_data, model(2'd0, '1, '1));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule